// File: doc/BRIEF.md
# First-Octant Sine/Cosine Tree Generator

This block turns an 8-bit unsigned code `n` into the sine and cosine of the angle n·π/1024. That angle always lies below π/4, so both results are non-negative and the whole datapath is unsigned. The block is purely combinational. It is meant to sit after an octant-folding stage that maps a full-circle phase into this range.

The code is cut into two 4-bit fields, and each field addresses its own 16-entry leaf table. The low field selects multiples of π/1024 and the high field selects multiples of π/64. Each leaf entry holds sine and cosine as 17-bit fractions. Bits whose value is the same in every entry of a leaf are not stored and are put back as constants: the leading zeros of a sine, and the leading ones of a cosine. The two leaf outputs are combined by an unsigned complex product built from four real multipliers, one adder for the sine and one subtracter for the cosine. Because the low leaf's sine is short, the two products that use it are 17×13 rather than 17×17. Both results are rounded to nearest with 8 fractional bits.

Top module: `sincos_tree`

## Requirements
- R1: The low 4 bits of `n_i` step the angle by π/1024, the high 4 bits by π/64, and the total angle is n·π/1024. As `n_i` counts upward, `sin_o` never decreases and `cos_o` never increases.
- R2: `sin_o` is an unsigned fraction with 8 fractional bits and no integer bit, within 1 LSB of 256·sin(n·π/1024) for every input code.
- R3: `cos_o` uses the same format and lies within 1 LSB of 256·cos(n·π/1024). A result that rounds to 1.0 saturates to 8'hFF.
- R4: For `n_i` = 0, `sin_o` is 0 and `cos_o` is 8'hFF.
- R5: Over the whole input range, `sin_o` never exceeds 181 and `cos_o` never drops below 181, which is the first-octant bound 256/√2.
- R6: The unsigned datapath never leaves its range. The sine sum never carries out of the 34-bit product width, the cosine difference never borrows, and the sine result never saturates, so `sin_o` never reads 8'hFF.
- R7: `sin_o`² + `cos_o`² stays within 1024 of 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| n_i | input | 8 | Angle code; the angle is n_i·π/1024 |
| sin_o | output | 8 | Sine, unsigned, 8 fractional bits |
| cos_o | output | 8 | Cosine, unsigned, 8 fractional bits, saturating |

## Verification
The checker evaluates its assertions whenever the combinational outputs settle. It takes for granted that `n_i` carries a known value, and skips any moment when the input is unknown. The range assertions (no carry, no borrow, octant bounds) depend on the input being unable to reach π/4, and the 8-bit code width guarantees this. The stimulus applies every one of the 256 codes in ascending order. It changes the input on one clock edge and reads the outputs half a period later, so every comparison sees settled values.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  // Fixed-point scale used only while building leaf tables at elaboration.
  localparam int     QF   = 28;
  localparam longint PI_Q = 64'sd843314857;  // pi * 2^28

  function automatic longint qmul(longint a, longint b);
    return (a * b) >>> QF;
  endfunction

  // angle k * pi / 2^shift in Q28
  function automatic longint angle_q(int k, int shift);
    return (PI_Q * longint'(k)) >>> shift;
  endfunction

  function automatic longint sin_q(longint x);
    longint x2, term, acc;
    x2   = qmul(x, x);
    term = x;
    acc  = x;
    for (int i = 1; i <= 5; i++) begin
      term = -qmul(term, x2) / longint'((2 * i) * (2 * i + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic longint cos_q(longint x);
    longint x2, term, acc;
    x2   = qmul(x, x);
    term = longint'(1) <<< QF;
    acc  = term;
    for (int i = 1; i <= 5; i++) begin
      term = -qmul(term, x2) / longint'((2 * i - 1) * (2 * i));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Round a Q28 value to fw fractional bits, clamped to [0, 2^fw - 1].
  function automatic longint to_frac(longint v, int fw);
    longint r, lim;
    r   = (v + (longint'(1) <<< (QF - fw - 1))) >>> (QF - fw);
    lim = (longint'(1) <<< fw) - 1;
    if (r > lim) r = lim;
    if (r < 0)   r = 0;
    return r;
  endfunction

  function automatic longint leaf_sin(int k, int shift, int fw);
    return to_frac(sin_q(angle_q(k, shift)), fw);
  endfunction

  function automatic longint leaf_cos(int k, int shift, int fw);
    return to_frac(cos_q(angle_q(k, shift)), fw);
  endfunction

  // Count the run of bits equal to `one` starting at the MSB of a w-bit value.
  function automatic int lead_run(longint v, int w, bit one);
    int  cnt;
    bit  live;
    cnt  = 0;
    live = 1'b1;
    for (int b = w - 1; b >= 0; b--) begin
      if (live && ((((v >> b) & 1) == 1) == one)) cnt++;
      else live = 1'b0;
    end
    return cnt;
  endfunction

  // Sine bits that are zero in every entry of a leaf.
  function automatic int sin_trim(int shift, int idx_w, int fw);
    longint mx, v;
    mx = 0;
    for (int k = 0; k < (1 << idx_w); k++) begin
      v = leaf_sin(k, shift, fw);
      if (v > mx) mx = v;
    end
    return lead_run(mx, fw, 1'b0);
  endfunction

  // Cosine bits that are one in every entry of a leaf.
  function automatic int cos_trim(int shift, int idx_w, int fw);
    longint mn, v;
    mn = longint'(1) <<< fw;
    for (int k = 0; k < (1 << idx_w); k++) begin
      v = leaf_cos(k, shift, fw);
      if (v < mn) mn = v;
    end
    return lead_run(mn, fw, 1'b1);
  endfunction

endpackage

// File: rtl/sincos_leaf.sv
module sincos_leaf
  import sincos_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int FRAC_W     = 17,
  parameter int STEP_SHIFT = 10,
  parameter int SIN_W      = FRAC_W - sin_trim(STEP_SHIFT, IDX_W, FRAC_W),
  parameter int COS_ST     = FRAC_W - cos_trim(STEP_SHIFT, IDX_W, FRAC_W)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [SIN_W-1:0]  sin_o,
  output logic [FRAC_W-1:0] cos_o
);

  localparam int DEPTH  = 2 ** IDX_W;
  localparam int COS_LO = FRAC_W - COS_ST;

  logic [SIN_W-1:0]  sin_rom [DEPTH];
  logic [COS_ST-1:0] cos_rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [SIN_W-1:0]  S_VAL = SIN_W'(leaf_sin(g, STEP_SHIFT, FRAC_W));
    localparam logic [COS_ST-1:0] C_VAL = COS_ST'(leaf_cos(g, STEP_SHIFT, FRAC_W));
    assign sin_rom[g] = S_VAL;
    assign cos_rom[g] = C_VAL;
  end

  assign sin_o = sin_rom[idx_i];

  if (COS_LO > 0) begin : g_ones
    assign cos_o = {{COS_LO{1'b1}}, cos_rom[idx_i]};
  end else begin : g_full
    assign cos_o = cos_rom[idx_i];
  end

endmodule

// File: rtl/sincos_umul.sv
module sincos_umul #(
  parameter int AW = 17,
  parameter int BW = 17,
  localparam int PW = AW + BW
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [PW-1:0] p_o
);

  assign p_o = PW'(a_i) * PW'(b_i);

endmodule

// File: rtl/sincos_round.sv
module sincos_round #(
  parameter int IN_W  = 34,
  parameter int SHIFT = 26,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] q_o,
  output logic             sat_o
);

  localparam int UW = IN_W + 1 - SHIFT;

  logic [IN_W:0]  biased;
  logic [UW-1:0]  upper;

  assign biased = {1'b0, val_i} + ((IN_W + 1)'(1) << (SHIFT - 1));
  assign upper  = biased[IN_W:SHIFT];
  assign sat_o  = |upper[UW-1:OUT_W];
  assign q_o    = sat_o ? {OUT_W{1'b1}} : upper[OUT_W-1:0];

endmodule

// File: rtl/sincos_tree.sv
module sincos_tree
  import sincos_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int FRAC_W     = 17,
  parameter int OUT_W      = 8,
  parameter int FINE_SHIFT = 10
) (
  input  logic [2*IDX_W-1:0] n_i,
  output logic [OUT_W-1:0]   sin_o,
  output logic [OUT_W-1:0]   cos_o
);

  localparam int COARSE_SHIFT = FINE_SHIFT - IDX_W;
  localparam int LO_SW = FRAC_W - sin_trim(FINE_SHIFT, IDX_W, FRAC_W);
  localparam int LO_CS = FRAC_W - cos_trim(FINE_SHIFT, IDX_W, FRAC_W);
  localparam int HI_SW = FRAC_W - sin_trim(COARSE_SHIFT, IDX_W, FRAC_W);
  localparam int HI_CS = FRAC_W - cos_trim(COARSE_SHIFT, IDX_W, FRAC_W);
  localparam int PW    = 2 * FRAC_W;

  logic [LO_SW-1:0]  lo_sin;
  logic [FRAC_W-1:0] lo_cos;
  logic [HI_SW-1:0]  hi_sin;
  logic [FRAC_W-1:0] hi_cos;

  sincos_leaf #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .STEP_SHIFT(FINE_SHIFT),
                .SIN_W(LO_SW), .COS_ST(LO_CS)) u_lo (
    .idx_i(n_i[IDX_W-1:0]), .sin_o(lo_sin), .cos_o(lo_cos));

  sincos_leaf #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .STEP_SHIFT(COARSE_SHIFT),
                .SIN_W(HI_SW), .COS_ST(HI_CS)) u_hi (
    .idx_i(n_i[2*IDX_W-1:IDX_W]), .sin_o(hi_sin), .cos_o(hi_cos));

  logic [HI_SW+FRAC_W-1:0] p_sc;   // hi sine   * lo cosine
  logic [FRAC_W+LO_SW-1:0] p_cs;   // hi cosine * lo sine  (short)
  logic [2*FRAC_W-1:0]     p_cc;   // hi cosine * lo cosine
  logic [HI_SW+LO_SW-1:0]  p_ss;   // hi sine   * lo sine  (short)

  sincos_umul #(.AW(HI_SW),  .BW(FRAC_W)) u_m_sc (.a_i(hi_sin), .b_i(lo_cos), .p_o(p_sc));
  sincos_umul #(.AW(FRAC_W), .BW(LO_SW))  u_m_cs (.a_i(hi_cos), .b_i(lo_sin), .p_o(p_cs));
  sincos_umul #(.AW(FRAC_W), .BW(FRAC_W)) u_m_cc (.a_i(hi_cos), .b_i(lo_cos), .p_o(p_cc));
  sincos_umul #(.AW(HI_SW),  .BW(LO_SW))  u_m_ss (.a_i(hi_sin), .b_i(lo_sin), .p_o(p_ss));

  // Named internal events for the checker.
  logic [PW:0] sin_sum;
  logic [PW:0] cos_diff;
  logic        sin_carry;
  logic        cos_borrow;
  logic        sin_sat;
  logic        cos_sat;

  assign sin_sum    = (PW + 1)'(p_sc) + (PW + 1)'(p_cs);
  assign cos_diff   = (PW + 1)'(p_cc) - (PW + 1)'(p_ss);
  assign sin_carry  = sin_sum[PW];
  assign cos_borrow = cos_diff[PW];

  sincos_round #(.IN_W(PW), .SHIFT(PW - OUT_W), .OUT_W(OUT_W)) u_rnd_s (
    .val_i(sin_sum[PW-1:0]), .q_o(sin_o), .sat_o(sin_sat));

  sincos_round #(.IN_W(PW), .SHIFT(PW - OUT_W), .OUT_W(OUT_W)) u_rnd_c (
    .val_i(cos_diff[PW-1:0]), .q_o(cos_o), .sat_o(cos_sat));

endmodule

// File: rtl/sincos_tree_chk.sv
module sincos_tree_chk #(
  parameter int N_W   = 8,
  parameter int OUT_W = 8
) (
  input logic [N_W-1:0]   n_i,
  input logic [OUT_W-1:0] sin_o,
  input logic [OUT_W-1:0] cos_o,
  input logic             sin_carry,
  input logic             cos_borrow,
  input logic             sin_sat
);

  localparam int OCT  = ((2 ** OUT_W) * 46341) / 65536;
  localparam int FULL = 2 ** (2 * OUT_W);
  localparam int TOL  = 4 * (2 ** OUT_W);

  int mag;
  assign mag = int'(sin_o) * int'(sin_o) + int'(cos_o) * int'(cos_o);

  always_comb begin
    if (!$isunknown(n_i)) begin
      assert_no_carry_R6: assert (!sin_carry)
        else $error("sine sum carried out");
      assert_no_borrow_R6: assert (!cos_borrow)
        else $error("cosine difference borrowed");
      assert_sin_unsat_R6: assert (!sin_sat)
        else $error("sine saturated");
      assert_sin_octant_R5: assert (int'(sin_o) <= OCT)
        else $error("sine above octant bound");
      assert_cos_octant_R5: assert (int'(cos_o) >= OCT)
        else $error("cosine below octant bound");
      assert_zero_angle_R4: assert (n_i != '0 || (sin_o == '0 && cos_o == '1))
        else $error("zero angle result wrong");
      assert_unit_mag_R7: assert (mag >= FULL - TOL && mag <= FULL + TOL)
        else $error("magnitude off unit circle");
    end
  end

endmodule

bind sincos_tree sincos_tree_chk #(.N_W(2 * IDX_W), .OUT_W(OUT_W)) u_chk (
  .n_i(n_i), .sin_o(sin_o), .cos_o(cos_o),
  .sin_carry(sin_carry), .cos_borrow(cos_borrow), .sin_sat(sin_sat));

// File: tb/sincos_tree_test.sv
module sincos_tree_test;

  localparam real PI = 3.14159265358979323846;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] n;
  logic [7:0] s_out, c_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sincos_tree uut (.n_i(n), .sin_o(s_out), .cos_o(c_out));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input real exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s n=%0d actual=%0d expected=%f", req, what, n, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int prev_s, prev_c;
    n = 8'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: zero code
    check(s_out == 8'd0,   "R4", "sin at zero", int'(s_out), 0.0);
    check(c_out == 8'hFF, "R4", "cos at zero", int'(c_out), 255.0);
    prev_s = -1;
    prev_c = 1000;
    for (int i = 0; i < 256; i++) begin
      real ang, es, ec, ds, dc;
      int  m;
      @(posedge clk);
      n = 8'(i);
      @(negedge clk);
      ang = real'(i) * PI / 1024.0;
      es  = $sin(ang) * 256.0;
      ec  = $cos(ang) * 256.0;
      ds  = real'(s_out) - es;
      dc  = real'(c_out) - ec;
      check(ds <= 1.0 && ds >= -1.0, "R2", "sine", int'(s_out), es);
      check(dc <= 1.0 && dc >= -1.0, "R3", "cosine", int'(c_out), ec);
      check(int'(s_out) >= prev_s, "R1", "sine order", int'(s_out), real'(prev_s));
      check(int'(c_out) <= prev_c, "R1", "cosine order", int'(c_out), real'(prev_c));
      check(int'(s_out) <= 181, "R5", "sine bound", int'(s_out), 181.0);
      check(int'(c_out) >= 181, "R5", "cosine bound", int'(c_out), 181.0);
      check(s_out != 8'hFF, "R6", "sine saturation", int'(s_out), 0.0);
      m = int'(s_out) * int'(s_out) + int'(c_out) * int'(c_out);
      check(m >= 65536 - 1024 && m <= 65536 + 1024, "R7", "magnitude", m, 65536.0);
      prev_s = int'(s_out);
      prev_c = int'(c_out);
    end
    // R3: code 1 still rounds to full scale, so it must saturate
    @(posedge clk);
    n = 8'd1;
    @(negedge clk);
    check(c_out == 8'hFF, "R3", "cos saturation", int'(c_out), 255.0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule